// File: doc/BRIEF.md
# Fixed-Frequency Hysteretic Current Regulator

This block regulates the current in an inductive load by switching one power device gate. An internal period counter sets the regulation frequency, and every decision is taken when that counter wraps. At each wrap the gate is forced on, because the load current is only observable while the switch conducts. The block then reads two comparator flags from an external sensing circuit. One says the current is below the lower edge of the hysteresis window. The other says the current has reached the peak level.

If the current is below the window when the cycle starts, the switch keeps conducting until the peak flag asserts. Otherwise it releases as soon as a minimum on-time has elapsed. The minimum on-time is derived from the period as 8% rounded up, and is never less than one clock. Once released, the switch stays off until the next wrap. A cycle that reaches its end without the peak keeps the gate on straight into the next one. A heavily inductive load can therefore show 100% duty over several cycles, and an apparent output frequency that is an integer fraction of the set one.

The block reports three things: a one-clock strobe at every cycle start, the number of on-clocks in the last completed cycle, and the number of consecutive cycles that ended with the gate still on.

Top module: `hyst_pwm_ctrl`

## Requirements
- R1: While rst_ni is low or en_i is low, gate_o and cyc_start_o are 0, and duty_o and run_o read 0 from the clock after en_i is sampled low.
- R2: The first clock edge that samples en_i high starts a cycle: in the clock that follows, cyc_start_o is 1 and gate_o is 1.
- R3: Strobes are spaced P clocks apart and each lasts one clock. P is period_i with values below 2 treated as 2, and period_i is captured at every cycle start.
- R4: The minimum on-time is M = max(1, ceil(8*P/100)) clocks. The gate, once turned on at a cycle start, stays on for at least M clocks of that cycle.
- R5: If the synchronized low flag (low_i) is 0 at the cycle start, the gate turns off after exactly M clocks, whatever peak_i does.
- R6: If the synchronized low flag is 1 at the cycle start, the gate stays on until the peak flag is seen. Both flags pass a two-flop synchronizer, so peak_i raised in clock j of the cycle (strobe clock is j = 0) turns the gate off after max(j+3, M) on-clocks.
- R7: A peak flag seen before the minimum on-time has expired takes effect only when it expires.
- R8: After the gate turns off within a cycle, it stays off until the next strobe, whatever the flags do.
- R9: A cycle in charge mode that never sees the peak keeps the gate on through its end and into the next cycle with no off clock.
- R10: In the strobe clock, duty_o shows how many clocks the gate was on during the previous completed cycle.
- R11: In the strobe clock, run_o shows the number of consecutive completed cycles that ended with the gate on, saturating at its maximum. A cycle ending with the gate off returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulation enable |
| period_i | input | CNT_W | Cycle length in clocks |
| peak_i | input | 1 | Comparator: current at or above the peak level |
| low_i | input | 1 | Comparator: current below the lower window edge |
| gate_o | output | 1 | Registered switch gate drive |
| cyc_start_o | output | 1 | One-clock strobe at each cycle start |
| duty_o | output | CNT_W | On-clocks in the last completed cycle |
| run_o | output | RUN_W | Consecutive cycles ending with the gate on |

## Verification
A corrupted cycle counter shows up within one period as a strobe spacing that differs from P, and in the same strobe clock as a duty_o reading. A wrong mode decision or a missed release shows on duty_o at the next strobe: it reads P, or a count that is neither M nor the peak-timed value. A release that is not latched makes gate_o rise without a strobe, which the bench sees on the clock it happens. The run count shows a lost carry-over state one strobe later.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic {
    MODE_TRIM   = 1'b0,  // release when min-on expires
    MODE_CHARGE = 1'b1   // hold until peak seen
  } cyc_mode_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/hp_cycle_timer.sv
module hp_cycle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             start_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] min_on_o
);
  localparam int MUL_W = CNT_W + 7;

  logic [CNT_W-1:0] cnt_q, per_q, mon_q, p_eff, mon_d;
  logic [MUL_W-1:0] prod;
  logic             run_q, strobe_q;

  assign p_eff = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
  // ceil(8*P/100)
  assign prod  = (MUL_W'(p_eff) << 3) + MUL_W'(99);
  assign mon_d = CNT_W'(prod / MUL_W'(100));

  assign start_o = en_i && (!run_q || cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      per_q    <= CNT_W'(2);
      mon_q    <= CNT_W'(1);
      run_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else if (start_o) begin
      cnt_q    <= '0;
      per_q    <= p_eff;
      mon_q    <= mon_d;
      run_q    <= 1'b1;
      strobe_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;
  assign cnt_o    = cnt_q;
  assign min_on_o = mon_q;
endmodule

// File: rtl/hp_gate_ctl.sv
module hp_gate_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] min_on_i,
  input  logic             peak_i,
  input  logic             low_i,
  output logic             gate_o
);
  import hp_pkg::*;

  cyc_mode_e mode_q;
  logic      gate_q, expired, release_now;

  // cnt_i is the pre-edge count, so the edge ending clock M sees M-1
  assign expired     = cnt_i >= (min_on_i - CNT_W'(1));
  assign release_now = gate_q && expired && (mode_q == MODE_TRIM || peak_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      mode_q <= MODE_TRIM;
    end else if (!en_i) begin
      gate_q <= 1'b0;
    end else if (start_i) begin
      gate_q <= 1'b1;
      mode_q <= low_i ? MODE_CHARGE : MODE_TRIM;
    end else if (release_now) begin
      gate_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hp_meter.sv
module hp_meter #(
  parameter int CNT_W = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] duty_o,
  output logic [RUN_W-1:0] run_o
);
  logic [CNT_W-1:0] acc_q, duty_q;
  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] acc_nx;

  assign acc_nx = acc_q + CNT_W'(gate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      duty_q <= '0;
      run_q  <= '0;
    end else if (!en_i) begin
      acc_q  <= '0;
      duty_q <= '0;
      run_q  <= '0;
    end else if (start_i) begin
      acc_q  <= '0;
      duty_q <= acc_nx;
      if (!gate_i)            run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + RUN_W'(1);
    end else begin
      acc_q  <= acc_nx;
    end
  end

  assign duty_o = duty_q;
  assign run_o  = run_q;
endmodule

// File: rtl/hyst_pwm_ctrl.sv
module hyst_pwm_ctrl #(
  parameter int CNT_W = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             peak_i,
  input  logic             low_i,
  output logic             gate_o,
  output logic             cyc_start_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [RUN_W-1:0] run_o
);
  logic [1:0]       flags_s;
  logic             start_now;
  logic [CNT_W-1:0] cnt_q, min_on_q;

  hp_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({peak_i, low_i}),
    .q_o   (flags_s)
  );

  hp_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .period_i(period_i),
    .start_o (start_now),
    .strobe_o(cyc_start_o),
    .cnt_o   (cnt_q),
    .min_on_o(min_on_q)
  );

  hp_gate_ctl #(.CNT_W(CNT_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_now),
    .cnt_i   (cnt_q),
    .min_on_i(min_on_q),
    .peak_i  (flags_s[1]),
    .low_i   (flags_s[0]),
    .gate_o  (gate_o)
  );

  hp_meter #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .start_i(start_now),
    .gate_i (gate_o),
    .duty_o (duty_o),
    .run_o  (run_o)
  );
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             gate_o,
  input logic             cyc_start_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] min_on_i
);
  // R1
  dis_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_o && !cyc_start_o));

  // R8
  gate_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> cyc_start_o);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);

  // R4
  min_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && $past(en_i)) |-> (cnt_i >= min_on_i));

  // R2
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> gate_o);
endmodule

bind hyst_pwm_ctrl hp_chk #(.CNT_W(CNT_W)) u_hp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .gate_o     (gate_o),
  .cyc_start_o(cyc_start_o),
  .cnt_i      (cnt_q),
  .min_on_i   (min_on_q)
);

// File: tb/test_hyst_pwm_ctrl.sv
module test_hyst_pwm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int RUN_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [CNT_W-1:0] period_i = CNT_W'(10);
  logic peak_i = 1'b0;
  logic low_i = 1'b0;
  logic gate_o, cyc_start_o;
  logic [CNT_W-1:0] duty_o;
  logic [RUN_W-1:0] run_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyst_pwm_ctrl #(.CNT_W(CNT_W), .RUN_W(RUN_W)) i_hyst_pwm_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .peak_i(peak_i), .low_i(low_i), .gate_o(gate_o),
    .cyc_start_o(cyc_start_o), .duty_o(duty_o), .run_o(run_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the negedge inside the strobe clock; n = clocks waited
  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cyc_start_o && n < 1000);
  endtask

  function automatic int min_on(input int p);
    int pe, m;
    pe = (p < 2) ? 2 : p;
    m = (pe * 8 + 99) / 100;
    return (m < 1) ? 1 : m;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    bit all_on;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(gate_o == 1'b0 && cyc_start_o == 1'b0, "R1 reset outputs", int'(gate_o), 0);
    chk(duty_o == '0 && run_o == '0, "R1 reset meters", int'(duty_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(gate_o == 1'b0 && cyc_start_o == 1'b0, "R1 disabled idle", int'(gate_o), 0);

    // R2: first start right after enable
    en_i = 1'b1;
    @(negedge clk);
    chk(cyc_start_o == 1'b1, "R2 first strobe", int'(cyc_start_o), 1);
    chk(gate_o == 1'b1, "R2 gate on at first start", int'(gate_o), 1);

    // R3, R4, R5: trim-mode sweep over period
    low_i = 1'b0; peak_i = 1'b0;
    for (int p = 0; p <= 60; p++) begin
      wait_start(n);
      period_i = CNT_W'(p);
      wait_start(n);               // start B latches p
      wait_start(n);               // start C
      chk(n == maxi(p, 2), $sformatf("R3 spacing p=%0d", p), n, maxi(p, 2));
      chk(int'(duty_o) == min_on(p), $sformatf("R5 R4 trim duty p=%0d", p),
          int'(duty_o), min_on(p));
    end

    // R5: trim ignores peak_i held high
    period_i = CNT_W'(60);
    peak_i = 1'b1;
    wait_start(n); wait_start(n); wait_start(n);
    chk(int'(duty_o) == 5, "R5 trim with peak", int'(duty_o), 5);

    // R6, R7: charge mode, peak raised j clocks into the cycle
    low_i = 1'b1; peak_i = 1'b0;
    wait_start(n); wait_start(n);
    for (int j = 0; j <= 50; j++) begin
      wait_start(n);
      peak_i = 1'b0;
      repeat (j) @(negedge clk);
      peak_i = 1'b1;
      wait_start(n);
      chk(int'(duty_o) == maxi(j + 3, 5), $sformatf("R6 R7 charge j=%0d", j),
          int'(duty_o), maxi(j + 3, 5));
      peak_i = 1'b0;
    end

    // R8: peak pulse then drop, gate stays off
    wait_start(n); wait_start(n);
    repeat (5) @(negedge clk);
    peak_i = 1'b1;
    repeat (5) @(negedge clk);
    peak_i = 1'b0;
    repeat (49) @(negedge clk);
    chk(gate_o == 1'b0, "R8 latched off in charge", int'(gate_o), 0);
    @(negedge clk);
    chk(cyc_start_o == 1'b1 && int'(duty_o) == 8, "R8 R10 pulse duty", int'(duty_o), 8);

    // R8: trim cycle, low rises mid-cycle
    low_i = 1'b0; peak_i = 1'b1;
    wait_start(n);
    peak_i = 1'b0;
    repeat (20) @(negedge clk);
    low_i = 1'b1;
    repeat (39) @(negedge clk);
    chk(gate_o == 1'b0, "R8 latched off in trim", int'(gate_o), 0);
    @(negedge clk);
    chk(int'(duty_o) == 5, "R8 trim duty", int'(duty_o), 5);

    // R9, R10, R11: carry-over with no peak, P=10
    low_i = 1'b0; peak_i = 1'b0; period_i = CNT_W'(10);
    wait_start(n); wait_start(n);  // trim cycles at P=10
    low_i = 1'b1;                  // cycle B will be charge
    wait_start(n);                 // B
    chk(int'(run_o) == 0, "R11 run after off end", int'(run_o), 0);
    all_on = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      for (int k = 0; k < 10; k++) begin
        if (!gate_o) all_on = 1'b0;
        @(negedge clk);
      end
      chk(cyc_start_o == 1'b1, $sformatf("R3 charge strobe c=%0d", c), int'(cyc_start_o), 1);
      chk(int'(run_o) == c, $sformatf("R11 run count c=%0d", c), int'(run_o), c);
      chk(int'(duty_o) == 10, $sformatf("R9 R10 full duty c=%0d", c), int'(duty_o), 10);
    end
    chk(all_on, "R9 no off gap across cycles", int'(all_on), 1);
    peak_i = 1'b1;
    wait_start(n);
    chk(int'(run_o) == 0, "R11 run cleared", int'(run_o), 0);
    chk(int'(duty_o) == 3, "R6 P=10 peak at strobe", int'(duty_o), 3);

    // R1: disable mid-run
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(gate_o == 1'b0 && cyc_start_o == 1'b0, "R1 disable gate", int'(gate_o), 0);
    chk(duty_o == '0 && run_o == '0, "R1 disable meters", int'(duty_o), 0);
    repeat (20) @(negedge clk);
    chk(gate_o == 1'b0 && cyc_start_o == 1'b0, "R1 stays off", int'(gate_o), 0);
    en_i = 1'b1;
    @(negedge clk);
    chk(cyc_start_o == 1'b1 && gate_o == 1'b1, "R2 restart", int'(cyc_start_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule